// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the physical layer of a slave on a single-wire, open-drain serial bus. The bus line idles high through an external pull-up, and every participant may only pull it low. The block watches the line, tells a master's bus reset apart from data time slots by how long the line stays low, and answers each bus reset with a presence pulse. In data slots it either receives the bit the master writes or, when the upper layer has loaded a byte to send, returns that byte's bits by stretching the master's low pulse for each 0 bit.

All timing is counted in microseconds from a tick derived from the system clock. The tick prescaler restarts at every timing reference point, so each window is an exact number of clock cycles after the event that opened it. Toward the upper layer the block gives per-bit and per-byte strobes, a byte-load input for transmit data and a one-cycle bus-reset strobe. Command decoding, speed modes and bus powering belong to other blocks.

Top module: `owire_slave_phy`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `line_pull_low`, `rx_bit_stb`, `rx_byte_stb`, `reset_stb` and `tx_busy` are 0 and `rx_byte` is all zeros.
- R2: `line_in` passes through a two-flop synchronizer. A slot opens on the first falling edge of the synchronized line seen while idle, so a slot that must return a 0 bit has `line_pull_low` high from the third rising clock edge after `line_in` goes low.
- R3: A data slot is sampled exactly T_SMP_US (default 30) microseconds, that is T_SMP_US*CLK_PER_US cycles, after the edge that opened it. `rx_bit` takes the synchronized line level and `rx_bit_stb` is high for one cycle. A low pulse of 1 to 15 µs therefore yields 1, and a low of 60 µs or more yields 0.
- R4: Bits are assembled least significant first. The first bit after a bus reset or after the previous byte lands in `rx_byte[0]`. On the eighth sample `rx_byte` is updated and `rx_byte_stb` is high in the same cycle as `rx_bit_stb`.
- R5: A `tx_load` pulse captures `tx_byte` and raises `tx_busy`. The next DATA_W slots carry its bits, least significant first. For a 0 bit, `line_pull_low` is high from the slot-opening edge until the sample edge. For a 1 bit, the line is never pulled. `tx_busy` falls at the DATA_W-th sample. A load in the same cycle as a sample takes precedence.
- R6: Slots used for transmission are also reported as received bits, so after sending a byte the next `rx_byte` equals the byte sent.
- R7: If the line is still low T_RST_US (default 480) µs after a slot opened, `reset_stb` pulses for one cycle. Any partly received byte and any pending transmit byte are discarded at that point.
- R8: After a bus reset, once the synchronized line is high again, the block waits T_PDH_US (default 30) µs and then holds `line_pull_low` for exactly T_PDL_US (default 120) µs.
- R9: A low period shorter than the reset threshold, even a long one such as 400 µs, is a 0 bit and raises no `reset_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the bus line as seen at the pin |
| line_pull_low | output | 1 | High to make the pad pull the bus line low |
| tx_load | input | 1 | One-cycle strobe to load a byte for transmission |
| tx_byte | input | DATA_W | Byte sent in following slots, least significant bit first |
| tx_busy | output | 1 | High while loaded transmit bits remain |
| rx_bit | output | 1 | Last sampled bit |
| rx_bit_stb | output | 1 | One-cycle strobe per sampled slot |
| rx_byte | output | DATA_W | Last completed received byte |
| rx_byte_stb | output | 1 | One-cycle strobe when a byte completes |
| reset_stb | output | 1 | One-cycle strobe when a bus reset is detected |

## Verification
A wrong slot state or timer value shows at the ports within one slot. Either a sample strobe moves away from its exact cycle, or the pull-low output opens or closes a cycle early or late, and the bench's cycle model compares both on every clock. A corrupted shift counter or shift register shows at the next byte boundary, as a byte strobe in the wrong slot or a wrong byte value. A transmit state that survives a bus reset shows in the first following slot, where it pulls the line and turns a written 1 into a received 0.

// File: rtl/owire_pkg.sv
package owire_pkg;

    // Default standard-speed windows, in microseconds
    localparam int OW_SMP_US = 30;
    localparam int OW_RST_US = 480;
    localparam int OW_PDH_US = 30;
    localparam int OW_PDL_US = 120;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // line high, waiting for a slot edge
        ST_LOW   = 3'd1,   // slot opened, waiting for the sample point
        ST_TAIL  = 3'd2,   // sampled, waiting for release or reset length
        ST_RHOLD = 3'd3,   // reset seen, waiting for the line to rise
        ST_PWAIT = 3'd4,   // gap before presence
        ST_PDRV  = 3'd5,   // presence pulse driven
        ST_PREL  = 3'd6    // presence released, waiting for high line
    } ow_state_e;

    typedef struct packed {
        logic stb;
        logic val;
    } ow_bit_t;

    function automatic int ow_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int N_STG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic fall
);
    logic [N_STG-1:0] stg;
    logic             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= '1;
            prev <= 1'b1;
        end else begin
            stg  <= {stg[N_STG-2:0], din};
            prev <= stg[N_STG-1];
        end
    end

    assign lvl  = stg[N_STG-1];
    assign fall = prev & ~stg[N_STG-1];

endmodule

// File: rtl/owire_ustimer.sv
module owire_ustimer #(
    parameter int CLK_PER_US = 125,
    parameter int US_MAX     = 480,
    localparam int PRE_W     = $clog2(CLK_PER_US + 1),
    localparam int US_W      = $clog2(US_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    output logic            tick,
    output logic [US_W-1:0] us
);
    logic [PRE_W-1:0] pre;

    assign tick = (pre == PRE_W'(CLK_PER_US - 1));

    always_ff @(posedge clk) begin
        if (rst || restart || tick) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            us <= '0;
        end else if (tick && (us != US_W'(US_MAX))) begin
            us <= us + 1'b1;
        end
    end

endmodule

// File: rtl/owire_slot_ctrl.sv
module owire_slot_ctrl
    import owire_pkg::*;
#(
    parameter int US_W      = 9,
    parameter int T_SMP_US  = OW_SMP_US,
    parameter int T_RST_US  = OW_RST_US,
    parameter int T_PDH_US  = OW_PDH_US,
    parameter int T_PDL_US  = OW_PDL_US
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_lvl,
    input  logic            line_fall,
    input  logic            tick,
    input  logic [US_W-1:0] us,
    input  logic            tx_pend,
    input  logic            tx_bit,
    output logic            restart,
    output ow_bit_t         smp,
    output logic            bus_rst,
    output logic            drive
);
    ow_state_e st, st_n;
    logic      drive_n;
    logic      hit_smp, hit_rst, hit_pdh, hit_pdl;

    // A window of N microseconds ends on the tick that moves us from N-1 to N
    assign hit_smp = tick && (us == US_W'(T_SMP_US - 1));
    assign hit_rst = tick && (us == US_W'(T_RST_US - 1));
    assign hit_pdh = tick && (us == US_W'(T_PDH_US - 1));
    assign hit_pdl = tick && (us == US_W'(T_PDL_US - 1));

    always_comb begin
        st_n    = st;
        drive_n = drive;
        restart = 1'b0;
        smp     = '0;
        bus_rst = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (line_fall) begin
                    st_n    = ST_LOW;
                    restart = 1'b1;
                    drive_n = tx_pend && !tx_bit;
                end
            end
            ST_LOW: begin
                if (hit_smp) begin
                    smp.stb = 1'b1;
                    smp.val = line_lvl;
                    drive_n = 1'b0;
                    st_n    = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (line_lvl) begin
                    st_n = ST_IDLE;
                end else if (hit_rst) begin
                    bus_rst = 1'b1;
                    drive_n = 1'b0;
                    st_n    = ST_RHOLD;
                end
            end
            ST_RHOLD: begin
                if (line_lvl) begin
                    st_n    = ST_PWAIT;
                    restart = 1'b1;
                end
            end
            ST_PWAIT: begin
                if (hit_pdh) begin
                    drive_n = 1'b1;
                    restart = 1'b1;
                    st_n    = ST_PDRV;
                end
            end
            ST_PDRV: begin
                if (hit_pdl) begin
                    drive_n = 1'b0;
                    st_n    = ST_PREL;
                end
            end
            ST_PREL: begin
                if (line_lvl) begin
                    st_n = ST_IDLE;
                end
            end
            default: begin
                st_n    = ST_IDLE;
                drive_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            drive <= 1'b0;
        end else begin
            st    <= st_n;
            drive <= drive_n;
        end
    end

endmodule

// File: rtl/owire_bitshift.sv
module owire_bitshift
    import owire_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  ow_bit_t           smp,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_bit,
    output logic              rx_bit_stb,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_byte_stb,
    output logic              tx_pend,
    output logic              tx_bit
);
    logic [DATA_W-1:0] rx_sh, tx_sh, rx_next;
    logic [CNT_W-1:0]  rx_n, tx_n;

    assign rx_next = {smp.val, rx_sh[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh       <= '0;
            rx_n        <= '0;
            rx_bit      <= 1'b0;
            rx_bit_stb  <= 1'b0;
            rx_byte     <= '0;
            rx_byte_stb <= 1'b0;
        end else begin
            rx_bit_stb  <= smp.stb;
            rx_byte_stb <= 1'b0;
            if (clr) begin
                rx_sh <= '0;
                rx_n  <= '0;
            end else if (smp.stb) begin
                rx_bit <= smp.val;
                rx_sh  <= rx_next;
                if (rx_n == CNT_W'(DATA_W - 1)) begin
                    rx_byte     <= rx_next;
                    rx_byte_stb <= 1'b1;
                    rx_n        <= '0;
                end else begin
                    rx_n <= rx_n + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tx_sh <= '0;
            tx_n  <= '0;
        end else if (tx_load) begin
            tx_sh <= tx_data;
            tx_n  <= CNT_W'(DATA_W);
        end else if (smp.stb && (tx_n != '0)) begin
            tx_sh <= {1'b0, tx_sh[DATA_W-1:1]};
            tx_n  <= tx_n - 1'b1;
        end
    end

    assign tx_pend = (tx_n != '0);
    assign tx_bit  = tx_sh[0];

endmodule

// File: rtl/owire_slave_phy.sv
module owire_slave_phy
    import owire_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int DATA_W     = 8,
    parameter int T_SMP_US   = OW_SMP_US,
    parameter int T_RST_US   = OW_RST_US,
    parameter int T_PDH_US   = OW_PDH_US,
    parameter int T_PDL_US   = OW_PDL_US
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    output logic              line_pull_low,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_busy,
    output logic              rx_bit,
    output logic              rx_bit_stb,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_byte_stb,
    output logic              reset_stb
);
    localparam int US_MAX = ow_max2(ow_max2(T_SMP_US, T_RST_US),
                                    ow_max2(T_PDH_US, T_PDL_US));
    localparam int US_W   = $clog2(US_MAX + 1);

    logic            line_lvl, line_fall;
    logic            restart, tick, bus_rst, tx_pend, tx_bit;
    logic [US_W-1:0] us;
    ow_bit_t         smp;

    owire_sync #(.N_STG(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_in),
        .lvl  (line_lvl),
        .fall (line_fall)
    );

    owire_ustimer #(.CLK_PER_US(CLK_PER_US), .US_MAX(US_MAX)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .us      (us)
    );

    owire_slot_ctrl #(
        .US_W     (US_W),
        .T_SMP_US (T_SMP_US),
        .T_RST_US (T_RST_US),
        .T_PDH_US (T_PDH_US),
        .T_PDL_US (T_PDL_US)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .line_lvl  (line_lvl),
        .line_fall (line_fall),
        .tick      (tick),
        .us        (us),
        .tx_pend   (tx_pend),
        .tx_bit    (tx_bit),
        .restart   (restart),
        .smp       (smp),
        .bus_rst   (bus_rst),
        .drive     (line_pull_low)
    );

    owire_bitshift #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .clr         (bus_rst),
        .smp         (smp),
        .tx_load     (tx_load),
        .tx_data     (tx_byte),
        .rx_bit      (rx_bit),
        .rx_bit_stb  (rx_bit_stb),
        .rx_byte     (rx_byte),
        .rx_byte_stb (rx_byte_stb),
        .tx_pend     (tx_pend),
        .tx_bit      (tx_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_stb <= 1'b0;
        end else begin
            reset_stb <= bus_rst;
        end
    end

    assign tx_busy = tx_pend;

endmodule

// File: rtl/owire_slave_phy_chk.sv
module owire_slave_phy_chk (
    input logic clk,
    input logic rst,
    input logic line_pull_low,
    input logic rx_bit_stb,
    input logic rx_byte_stb,
    input logic reset_stb,
    input logic tx_busy
);
    AST_BYTE_WITH_BIT: assert property (@(posedge clk) disable iff (rst) rx_byte_stb |-> rx_bit_stb); // R4
    AST_BIT_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_bit_stb |=> !rx_bit_stb); // R3
    AST_RESET_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) reset_stb |=> !reset_stb); // R7
    AST_RESET_DROPS_TX: assert property (@(posedge clk) disable iff (rst) reset_stb |-> !tx_busy); // R7
    AST_RESET_NO_BIT: assert property (@(posedge clk) disable iff (rst) reset_stb |-> !rx_bit_stb); // R7
    AST_RESET_NO_PULL: assert property (@(posedge clk) disable iff (rst) reset_stb |-> !line_pull_low); // R8
    AST_SAMPLE_RELEASES: assert property (@(posedge clk) disable iff (rst) rx_bit_stb |-> !line_pull_low); // R5
endmodule

bind owire_slave_phy owire_slave_phy_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .line_pull_low (line_pull_low),
    .rx_bit_stb    (rx_bit_stb),
    .rx_byte_stb   (rx_byte_stb),
    .reset_stb     (reset_stb),
    .tx_busy       (tx_busy)
);

// File: tb/sim_owire_slave_phy.sv
`timescale 1ns/1ps
module sim_owire_slave_phy;
    localparam int CPU  = 4;
    localparam int SMP  = 30;
    localparam int RSTT = 480;
    localparam int PDH  = 30;
    localparam int PDL  = 120;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_low = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       line_in;
    logic       line_pull_low, tx_busy, rx_bit, rx_bit_stb, rx_byte_stb, reset_stb;
    logic [7:0] rx_byte;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // wired-AND bus: the master or the slave may pull low
    assign line_in = !(m_low || line_pull_low);

    owire_slave_phy #(.CLK_PER_US(CPU)) u0 (
        .clk           (clk),
        .rst           (rst),
        .line_in       (line_in),
        .line_pull_low (line_pull_low),
        .tx_load       (tx_load),
        .tx_byte       (tx_byte),
        .tx_busy       (tx_busy),
        .rx_bit        (rx_bit),
        .rx_bit_stb    (rx_bit_stb),
        .rx_byte       (rx_byte),
        .rx_byte_stb   (rx_byte_stb),
        .reset_stb     (reset_stb)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         mst, cnt, c0, txn, rxn;
    logic [7:0] txq, rxq, e_byte;
    logic       e_pull, e_bstb, e_bit, e_ystb, e_rstb, e_busy;
    logic       s1, ls, ld, lv, smp_now, clr_now;

    always @(posedge clk) begin
        lv = !(m_low || e_pull);
        if (rst) begin
            mst = 0; cnt = 0; txn = 0; rxn = 0; txq = 0; rxq = 0;
            e_pull = 0; e_bstb = 0; e_bit = 0; e_ystb = 0; e_byte = 0;
            e_rstb = 0; e_busy = 0; s1 = 1; ls = 1; ld = 1;
        end else begin
            c0 = cnt; cnt = cnt + 1;
            e_bstb = 0; e_ystb = 0; e_rstb = 0; smp_now = 0; clr_now = 0;
            case (mst)
                0: if (ld && !ls) begin
                       mst = 1; cnt = 0;
                       if (txn > 0 && !txq[0]) e_pull = 1;
                   end
                1: if (c0 == SMP*CPU-1) begin smp_now = 1; e_pull = 0; mst = 2; end
                2: if (ls) mst = 0;
                   else if (c0 == RSTT*CPU-1) begin clr_now = 1; e_pull = 0; mst = 3; end
                3: if (ls) begin mst = 4; cnt = 0; end
                4: if (c0 == PDH*CPU-1) begin e_pull = 1; mst = 5; cnt = 0; end
                5: if (c0 == PDL*CPU-1) begin e_pull = 0; mst = 6; end
                6: if (ls) mst = 0;
                default: mst = 0;
            endcase
            if (smp_now) begin
                e_bstb = 1; e_bit = ls;
                rxq = {ls, rxq[7:1]}; rxn = rxn + 1;
                if (rxn == 8) begin e_ystb = 1; e_byte = rxq; rxn = 0; end
                if (txn > 0) begin txq = txq >> 1; txn = txn - 1; end
            end
            if (tx_load) begin txq = tx_byte; txn = 8; end
            if (clr_now) begin e_rstb = 1; txn = 0; rxn = 0; end
            e_busy = (txn > 0);
            ld = ls; ls = s1; s1 = lv;
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int         nbytes = 0, nrst = 0, pull_cyc = 0;
    logic [7:0] last_byte = 8'h00;
    logic       last_bit = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(line_pull_low === e_pull, "R2/R5/R8 pull", line_pull_low, e_pull);
            chk(rx_bit_stb === e_bstb, "R3 bit strobe", rx_bit_stb, e_bstb);
            chk(rx_bit === e_bit, "R3 bit value", rx_bit, e_bit);
            chk(rx_byte_stb === e_ystb, "R4 byte strobe", rx_byte_stb, e_ystb);
            chk(rx_byte === e_byte, "R4 byte value", rx_byte, e_byte);
            chk(reset_stb === e_rstb, "R7 reset strobe", reset_stb, e_rstb);
            chk(tx_busy === e_busy, "R5 busy", tx_busy, e_busy);
            if (rx_byte_stb) begin nbytes++; last_byte = rx_byte; end
            if (rx_bit_stb) last_bit = rx_bit;
            if (reset_stb) nrst++;
            if (line_pull_low) pull_cyc++;
        end
    end

    // ---------------- master-side tasks ----------------
    task automatic wait_us(input int n);
        repeat (n*CPU) @(negedge clk);
    endtask

    task automatic slot_w(input bit b);
        m_low = 1'b1;
        if (b) begin wait_us(5); m_low = 1'b0; wait_us(65); end
        else begin wait_us(70); m_low = 1'b0; wait_us(5); end
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) slot_w(v[i]);
    endtask

    task automatic read_bit(output logic r);
        m_low = 1'b1; wait_us(2); m_low = 1'b0; wait_us(11);
        r = line_in;
        wait_us(62);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic r;
        for (int i = 0; i < 8; i++) begin read_bit(r); v[i] = r; end
    endtask

    task automatic load(input logic [7:0] v);
        tx_byte = v; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic bus_reset();
        int r0, d, p;
        r0 = nrst;
        m_low = 1'b1; wait_us(500); m_low = 1'b0;
        d = 0;
        while (!line_pull_low && d < 2000) begin @(negedge clk); d++; end
        chk(d == PDH*CPU+3, "R8 presence delay", d, PDH*CPU+3);
        p = 0;
        while (line_pull_low && p < 4000) begin @(negedge clk); p++; end
        chk(p == PDL*CPU, "R8 presence length", p, PDL*CPU);
        wait_us(10);
        chk(nrst - r0 == 1, "R7 one reset strobe", nrst - r0, 1);
    endtask

    initial begin
        logic [7:0] got;
        logic a, b, c, r;
        int b0, r0, p0;
        repeat (5) @(negedge clk);
        chk(line_pull_low == 0 && tx_busy == 0 && rx_bit_stb == 0, "R1 reset outputs", {line_pull_low, tx_busy, rx_bit_stb}, 0);
        chk(rx_byte == 8'h00 && reset_stb == 0 && rx_byte_stb == 0, "R1 reset data", rx_byte, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(line_pull_low == 0 && tx_busy == 0 && reset_stb == 0, "R1 after release", {line_pull_low, tx_busy, reset_stb}, 0);
        wait_us(5);

        bus_reset();

        slot_w(1'b1);
        chk(last_bit == 1'b1, "R3 write-1 slot", last_bit, 1);
        slot_w(1'b0);
        chk(last_bit == 1'b0, "R3 write-0 slot", last_bit, 0);
        bus_reset();   // discards the two partial bits

        b0 = nbytes;
        write_byte(8'hA5);
        chk(nbytes - b0 == 1, "R7 partial byte discarded", nbytes - b0, 1);
        chk(last_byte == 8'hA5, "R4 byte A5 lsb first", last_byte, 8'hA5);
        write_byte(8'h3C);
        chk(last_byte == 8'h3C, "R4 byte 3C lsb first", last_byte, 8'h3C);

        // long low below the reset threshold
        r0 = nrst;
        m_low = 1'b1; wait_us(400); m_low = 1'b0; wait_us(10);
        chk(nrst == r0, "R9 no reset strobe", nrst - r0, 0);
        chk(last_bit == 1'b0, "R9 long low is 0", last_bit, 0);
        bus_reset();

        // transmit 5A; first slot probes the synchronizer latency
        load(8'h5A);
        chk(tx_busy == 1'b1, "R5 busy after load", tx_busy, 1);
        m_low = 1'b1;
        @(negedge clk); a = line_pull_low;
        @(negedge clk); b = line_pull_low;
        @(negedge clk); c = line_pull_low;
        chk(a == 0 && b == 0 && c == 1, "R2 pull on third edge", {a, b, c}, 3'b001);
        repeat (2*CPU-3) @(negedge clk);
        m_low = 1'b0; wait_us(11);
        r = line_in;
        wait_us(62);
        got[0] = r;
        for (int i = 1; i < 8; i++) begin read_bit(r); got[i] = r; end
        chk(got == 8'h5A, "R5 master reads 5A", got, 8'h5A);
        chk(tx_busy == 1'b0, "R5 busy clears", tx_busy, 0);
        chk(last_byte == 8'h5A, "R6 sent byte echoed", last_byte, 8'h5A);

        // all-ones transmit never pulls
        p0 = pull_cyc;
        load(8'hFF);
        read_byte(got);
        chk(got == 8'hFF, "R5 master reads FF", got, 8'hFF);
        chk(pull_cyc == p0, "R5 no pull for 1 bits", pull_cyc - p0, 0);

        // pending transmit dropped by a bus reset
        load(8'h00);
        bus_reset();
        chk(tx_busy == 1'b0, "R7 transmit dropped", tx_busy, 0);
        write_byte(8'hFF);
        chk(last_byte == 8'hFF, "R7 no stale pull", last_byte, 8'hFF);

        wait_us(5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(64'd200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule